// File: doc/BRIEF.md
# Chromatic Encoder Step Selector

This block turns the detents of a debounced two-pin rotary encoder into steps along a chromatic index. The index picks a playback speed word in 8.8 fixed point from a fixed table of semitone ratios. The table runs from one octave down to one octave up, so the speed word goes from half speed to double speed. A sample-rate playback engine uses the speed word as its read-pointer increment. That engine, and the debounce circuit on the encoder pins, sit outside this block.

The pins are not watched on every clock. A down-counter that advances on the sample tick chooses one sample tick in every 64, and only that tick looks at the pins. On such a tick, a low clock pin whose low period has not yet been counted makes one step. The level of the direction pin at that moment picks the way of the step. A flag then blocks further steps until a later sampled tick sees the clock pin high again. The index saturates at both ends. The speed word sits in a register and is rewritten on the same edge as the index.

Top module: `chroma_step_sel`

## Requirements
- R1: The encoder pins are looked at only on every 64th sample tick after reset. A down-counter reloaded with 64 selects that tick. Pin activity that starts and ends between two such ticks has no effect on the index.
- R2: Each low period of enc_clk, as seen at the selected ticks, gives at most one step. The step is armed again only after a selected tick sees enc_clk high.
- R3: At a step, enc_dir = 1 decrements the index (left turn) and enc_dir = 0 increments it (right turn).
- R4: The index stays within 0 to 24, and reset sets it to 12.
- R5: A decrement while the index is 0 leaves it at 0. An increment while it is 24 leaves it at 24.
- R6: speed_word equals the ratio entry for the current index. In hex, from index 0 to 24, the entries are 0080 0088 0090 0098 00A1 00AB 00B5 00C0 00CB 00D7 00E4 00F2 0100 010F 011F 0130 0143 0156 016A 0180 0196 01AF 01C8 01E3 0200, which is round(256 * 2^((index-12)/12)). Reset gives 0x0100.
- R7: On the clock edge where the selected tick takes a step, step_index and speed_word both take their new values. No other value of speed_word appears between the two settled states.
- R8: The armed state is clear at reset, so if enc_clk is already low at the first selected tick, a step is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_tick | input | 1 | One-cycle strobe per audio sample |
| enc_clk | input | 1 | Debounced encoder pin whose falling edge marks a detent |
| enc_dir | input | 1 | Debounced encoder pin giving the direction at the detent |
| step_index | output | 5 | Chromatic index, 0 to 24 |
| speed_word | output | 16 | Playback increment in 8.8 fixed point |

## Verification
The assertions assume that sample_tick and both encoder pins are synchronous to clk and hold steady across each clock edge. They also assume the pins are already debounced, so one sampled low period corresponds to one detent. The stimulus changes every input on the falling clock edge only. It holds each pin level for at least one full window of 64 ticks, except in the short-glitch case. It runs with ticks on every cycle and with ticks on every second cycle, and the reference model follows both cadences.

// File: rtl/chroma_step_pkg.sv
package chroma_step_pkg;

   // number of table entries on each side of unity speed
   localparam int unsigned FULL_SPAN = 12;
   localparam int unsigned TABLE_LEN = 2 * FULL_SPAN + 1;

   // Semitone ratio in 8.8 fixed point, entry FULL_SPAN is unity.
   function automatic logic [15:0] semitone_ratio(input int unsigned k);
      logic [15:0] r;
      case (k)
         0:  r = 16'h0080;
         1:  r = 16'h0088;
         2:  r = 16'h0090;
         3:  r = 16'h0098;
         4:  r = 16'h00A1;
         5:  r = 16'h00AB;
         6:  r = 16'h00B5;
         7:  r = 16'h00C0;
         8:  r = 16'h00CB;
         9:  r = 16'h00D7;
         10: r = 16'h00E4;
         11: r = 16'h00F2;
         12: r = 16'h0100;
         13: r = 16'h010F;
         14: r = 16'h011F;
         15: r = 16'h0130;
         16: r = 16'h0143;
         17: r = 16'h0156;
         18: r = 16'h016A;
         19: r = 16'h0180;
         20: r = 16'h0196;
         21: r = 16'h01AF;
         22: r = 16'h01C8;
         23: r = 16'h01E3;
         24: r = 16'h0200;
         default: r = 16'h0100;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/chroma_tick_div.sv
module chroma_tick_div #(
   parameter int unsigned RATIO = 64
) (
   input  logic clk,
   input  logic rst,
   input  logic tick_i,
   output logic strobe_o
);
   localparam int unsigned CNT_W = (RATIO < 2) ? 1 : $clog2(RATIO + 1);

   if (RATIO < 1) begin : g_bad_ratio
      $error("chroma_tick_div: RATIO must be at least 1");
   end

   if (RATIO == 1) begin : g_pass
      assign strobe_o = tick_i;
   end else begin : g_count
      logic [CNT_W-1:0] cnt_q;

      assign strobe_o = tick_i && (cnt_q == CNT_W'(1));

      always_ff @(posedge clk) begin
         if (rst) begin
            cnt_q <= CNT_W'(RATIO);
         end else if (tick_i) begin
            if (cnt_q == CNT_W'(1)) cnt_q <= CNT_W'(RATIO);
            else                    cnt_q <= cnt_q - CNT_W'(1);
         end
      end

      AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
         (cnt_q >= CNT_W'(1)) && (cnt_q <= CNT_W'(RATIO)))
         else $error("divider count out of range"); // R1
      AST_CNT_HOLDS: assert property (@(posedge clk) disable iff (rst)
         !tick_i |=> $stable(cnt_q))
         else $error("divider moved without a tick"); // R1
   end

   AST_STROBE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
      strobe_o |-> tick_i)
      else $error("sample strobe without tick"); // R1

endmodule

// File: rtl/chroma_edge_det.sv
module chroma_edge_det (
   input  logic clk,
   input  logic rst,
   input  logic strobe_i,
   input  logic pin_clk_i,
   input  logic pin_dir_i,
   output logic step_o,
   output logic down_o
);
   logic armed_used_q;

   assign step_o = strobe_i && !pin_clk_i && !armed_used_q;
   assign down_o = pin_dir_i;

   always_ff @(posedge clk) begin
      if (rst) begin
         armed_used_q <= 1'b0;
      end else if (strobe_i) begin
         if (pin_clk_i)          armed_used_q <= 1'b0;
         else if (!armed_used_q) armed_used_q <= 1'b1;
      end
   end

   AST_ONE_STEP_PER_LOW: assert property (@(posedge clk) disable iff (rst)
      step_o |=> armed_used_q)
      else $error("step did not mark the low period"); // R2
   AST_REARM_ON_HIGH: assert property (@(posedge clk) disable iff (rst)
      (strobe_i && pin_clk_i) |=> !armed_used_q)
      else $error("flag did not clear on high sample"); // R2
   AST_FLAG_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
      !strobe_i |=> $stable(armed_used_q))
      else $error("flag moved between samples"); // R1

endmodule

// File: rtl/chroma_index_ctl.sv
module chroma_index_ctl
   import chroma_step_pkg::*;
#(
   parameter int unsigned SPAN    = 12,
   parameter int unsigned SPEED_W = 16
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  step_i,
   input  logic                  down_i,
   output logic [$clog2(2*SPAN+1)-1:0] idx_o,
   output logic [SPEED_W-1:0]    speed_o
);
   localparam int unsigned IDX_W   = $clog2(2 * SPAN + 1);
   localparam int unsigned MAX_IDX = 2 * SPAN;
   localparam int unsigned OFFSET  = FULL_SPAN - SPAN;

   if (SPAN < 1 || SPAN > FULL_SPAN) begin : g_bad_span
      $error("chroma_index_ctl: SPAN must be 1..12");
   end
   if (SPEED_W < 10) begin : g_bad_width
      $error("chroma_index_ctl: SPEED_W must hold 0x200");
   end

   logic [IDX_W-1:0]   idx_q, idx_nx;
   logic [SPEED_W-1:0] speed_q;
   logic               at_top, at_bot;

   assign at_top = (idx_q == IDX_W'(MAX_IDX));
   assign at_bot = (idx_q == '0);

   always_comb begin
      idx_nx = idx_q;
      if (step_i) begin
         if (down_i) begin
            if (!at_bot) idx_nx = idx_q - IDX_W'(1);
         end else begin
            if (!at_top) idx_nx = idx_q + IDX_W'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         idx_q   <= IDX_W'(SPAN);
         speed_q <= SPEED_W'(semitone_ratio(FULL_SPAN));
      end else begin
         idx_q   <= idx_nx;
         speed_q <= SPEED_W'(semitone_ratio(int'(unsigned'(idx_nx)) + OFFSET));
      end
   end

   assign idx_o   = idx_q;
   assign speed_o = speed_q;

   AST_IDX_BOUND: assert property (@(posedge clk) disable iff (rst)
      idx_q <= IDX_W'(MAX_IDX))
      else $error("index beyond top"); // R4
   AST_IDX_UNIT_STEP: assert property (@(posedge clk) disable iff (rst)
      !$stable(idx_q) |-> ((idx_q == $past(idx_q) + IDX_W'(1)) ||
                          (idx_q == $past(idx_q) - IDX_W'(1))))
      else $error("index jumped by more than one"); // R3
   AST_NO_STEP_NO_MOVE: assert property (@(posedge clk) disable iff (rst)
      !step_i |=> $stable(idx_q))
      else $error("index moved without a step"); // R1
   AST_SAT_TOP: assert property (@(posedge clk) disable iff (rst)
      (at_top && step_i && !down_i) |=> $stable(idx_q))
      else $error("increment past top"); // R5
   AST_SAT_BOT: assert property (@(posedge clk) disable iff (rst)
      (at_bot && step_i && down_i) |=> $stable(idx_q))
      else $error("decrement past bottom"); // R5
   AST_SPEED_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      !$stable(idx_q) |-> !$stable(speed_q))
      else $error("speed lagged index"); // R7
   AST_SPEED_HOLDS: assert property (@(posedge clk) disable iff (rst)
      $stable(idx_q) |-> $stable(speed_q))
      else $error("speed moved without index"); // R7

endmodule

// File: rtl/chroma_step_sel.sv
module chroma_step_sel #(
   parameter int unsigned SUB_RATIO = 64,
   parameter int unsigned SPAN      = 12,
   parameter int unsigned SPEED_W   = 16
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         sample_tick,
   input  logic                         enc_clk,
   input  logic                         enc_dir,
   output logic [$clog2(2*SPAN+1)-1:0]  step_index,
   output logic [SPEED_W-1:0]           speed_word
);
   logic look_now, step, down;

   chroma_tick_div #(.RATIO(SUB_RATIO)) u_div (
      .clk      (clk),
      .rst      (rst),
      .tick_i   (sample_tick),
      .strobe_o (look_now)
   );

   chroma_edge_det u_edge (
      .clk       (clk),
      .rst       (rst),
      .strobe_i  (look_now),
      .pin_clk_i (enc_clk),
      .pin_dir_i (enc_dir),
      .step_o    (step),
      .down_o    (down)
   );

   chroma_index_ctl #(.SPAN(SPAN), .SPEED_W(SPEED_W)) u_idx (
      .clk     (clk),
      .rst     (rst),
      .step_i  (step),
      .down_i  (down),
      .idx_o   (step_index),
      .speed_o (speed_word)
   );

endmodule

// File: tb/test_chroma_step_sel.sv
module test_chroma_step_sel;
   logic clk = 1'b0, rst = 1'b1, tick = 1'b0, enc_a = 1'b0, enc_b = 1'b0;
   logic [4:0]  idx;
   logic [15:0] spd;
   int checks = 0, failures = 0;
   int m_cnt = 64, m_idx = 12;
   bit m_flag = 1'b0, cmp_on = 1'b0;

   always #5 clk = ~clk;

   chroma_step_sel i_chroma_step_sel (
      .clk(clk), .rst(rst), .sample_tick(tick), .enc_clk(enc_a),
      .enc_dir(enc_b), .step_index(idx), .speed_word(spd)
   );

   function automatic int exp_speed(int k);
      real r;
      r = 256.0 * (2.0 ** ((k - 12) / 12.0));
      return $rtoi(r + 0.5);
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // behavioural reference, advanced on each rising edge
   always @(posedge clk) begin
      if (rst) begin
         m_cnt = 64; m_flag = 1'b0; m_idx = 12;
      end else if (tick) begin
         if (m_cnt == 1) begin
            m_cnt = 64;
            if (enc_a) m_flag = 1'b0;
            else if (!m_flag) begin
               m_flag = 1'b1;
               if (enc_b) begin if (m_idx > 0) m_idx--; end
               else if (m_idx < 24) m_idx++;
            end
         end else m_cnt--;
      end
   end

   always @(negedge clk) begin
      if (cmp_on && !rst) begin
         chk(int'(idx) == m_idx, "R7 index vs model", idx, m_idx);
         chk(int'(spd) == exp_speed(m_idx), "R7 speed vs model", spd, exp_speed(m_idx));
      end
   end

   task automatic ticks(int n, bit sparse = 1'b0);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) tick = 1'b1;
         if (sparse) @(negedge clk) tick = 1'b0;
      end
      @(negedge clk) tick = 1'b0;
   endtask

   task automatic detent(bit left, bit sparse = 1'b0);
      enc_b = left; enc_a = 1'b0;
      ticks(64, sparse);
      enc_a = 1'b1;
      ticks(64, sparse);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      cmp_on = 1'b1;
      chk(idx == 5'd12, "R4 reset index", idx, 12);
      chk(spd == 16'h0100, "R6 reset speed", spd, 16'h0100);

      // enc_a low from reset: nothing until the 64th tick
      ticks(63);
      chk(idx == 5'd12, "R1 before 64th tick", idx, 12);
      ticks(1);
      chk(idx == 5'd13, "R8 low at first sample steps", idx, 13);

      // long low period gives a single step
      ticks(192);
      chk(idx == 5'd13, "R2 held low one step", idx, 13);
      enc_a = 1'b1;
      ticks(64);
      chk(idx == 5'd13, "R2 high sample no step", idx, 13);

      for (int i = 0; i < 11; i++) detent(1'b0);
      chk(idx == 5'd24, "R3 right turns increment", idx, 24);
      chk(spd == 16'h0200, "R6 top speed", spd, 16'h0200);
      for (int i = 0; i < 3; i++) detent(1'b0);
      chk(idx == 5'd24, "R5 saturate at top", idx, 24);

      // short low glitch between samples is not seen
      enc_b = 1'b1;
      ticks(20);
      enc_a = 1'b0; ticks(10);
      enc_a = 1'b1; ticks(34);
      chk(idx == 5'd24, "R1 glitch ignored", idx, 24);

      detent(1'b1);
      chk(idx == 5'd23, "R3 left turn decrements", idx, 23);
      chk(spd == 16'h01E3, "R6 speed at 23", spd, 16'h01E3);
      for (int i = 0; i < 30; i++) detent(1'b1);
      chk(idx == 5'd0, "R5 saturate at bottom", idx, 0);
      chk(spd == 16'h0080, "R6 bottom speed", spd, 16'h0080);

      // sweep upward with sparse ticks, checking every table entry
      for (int k = 1; k <= 24; k++) begin
         detent(1'b0, 1'b1);
         chk(int'(idx) == k, "R3 sweep index", idx, k);
         chk(int'(spd) == exp_speed(k), "R6 sweep speed", spd, exp_speed(k));
      end

      detent(1'b1, 1'b1);
      detent(1'b0);
      detent(1'b1);
      chk(idx == 5'd23, "R7 mixed turns", idx, 23);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule